// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt request messages for one processor core and decides which interrupt, if any, is presented to that core. Each message carries an 8-bit vector, a 3-bit delivery mode and a level/edge flag. Ordinary requests are stored in a 256-entry request array, one bit per vector, and a trigger array records level or edge for each entry. A 256-entry in-service array and a task-priority value decide whether the highest stored request may interrupt the core. The core takes the offered interrupt with an acknowledge pulse and retires a finished handler with an end-of-interrupt pulse.

System-management, non-maskable and init requests skip the arrays. Each one goes into a one-deep pending slot that holds its vector. These slots are offered to the core even when the core has interrupts disabled. An external-controller request also has a one-deep slot, but the core interrupt-enable flag masks it. The slots and the arrays share one fixed order of precedence. An acknowledge retires only the source that was offered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A request with mode code 0 (fixed) or 1 (lowest priority) sets the request bit of its vector. With interrupts enabled, an empty in-service array and task priority 0, the controller then offers kind 5 (regular) with that vector whenever vector bits 7:4 are nonzero.
- R2: When a regular request sets a request bit that was clear, the trigger bit of that vector takes the level flag (1 = level, 0 = edge). `irq_level` shows the trigger bit of the offered vector while the kind is 5, and is 0 otherwise.
- R3: A regular request for a vector whose request bit is already set leaves that vector's trigger bit unchanged.
- R4: Mode 2 (system management), mode 4 (non-maskable) and mode 5 (init) each set a one-deep pending slot and latch the vector. While a slot is set, a further request of the same mode is dropped and the latched vector is kept. Once the slot is acknowledged, a new request of that mode is accepted.
- R5: Mode 7 (external) sets its own pending slot and latches the vector. It is offered as kind 4 only while `core_ie` is 1.
- R6: A pending system-management, non-maskable or init slot is offered (kinds 1, 2, 3) whatever the value of `core_ie`.
- R7: A regular interrupt is offered only when `core_ie` is 1, the highest requested vector is above the highest in-service vector (or nothing is in service), and its bits 7:4 are greater than task-priority bits 7:4.
- R8: Offer order is kind 1, then 2, then 3, then 4, then 5. An acknowledge removes only the source that was offered, and the next source in that order then appears.
- R9: Acknowledging kind 5 clears the request bit of the offered vector and sets its in-service bit. The highest remaining request is then judged against the new in-service state.
- R10: An end-of-interrupt pulse clears the in-service bit of the highest in-service vector. A lower request that was blocked may then be offered.
- R11: A task-priority write keeps only bits 7:0 of `tpr_wdata`. The higher bits have no effect on gating.
- R12: Requests with the reserved mode codes 3 and 6 are ignored. No slot and no request bit changes.
- R13: When nothing is offered, `irq_pending` is 0, `irq_kind` is 0 and `irq_vector` is 0. An acknowledge while nothing is offered changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present this cycle |
| req_vector | input | 8 | Vector of the request |
| req_mode | input | 3 | Delivery mode code (0,1 regular; 2 SMM; 4 NMI; 5 init; 7 external; 3,6 reserved) |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| core_ie | input | 1 | Core interrupt-enable flag |
| ack | input | 1 | Core takes the offered interrupt |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data (bits 7:0 kept) |
| irq_pending | output | 1 | An interrupt is offered to the core |
| irq_vector | output | 8 | Vector of the offered interrupt |
| irq_kind | output | 3 | 0 none, 1 SMM, 2 NMI, 3 init, 4 external, 5 regular |
| irq_level | output | 1 | Trigger bit of the offered regular vector |

## Verification
The hardest state to reach is one where the in-service array holds several vectors while lower requests wait behind them. Only a regular acknowledge can fill the in-service array, so the stimulus first raises a vector, acknowledges it, and then raises more vectors above and below it. It then checks that each end-of-interrupt releases exactly the next blocked request. All 256 vectors are swept through request, acknowledge and end-of-interrupt, and every pair of vector class and task-priority class is swept with junk in the upper write bits. Before the special slots are acknowledged one at a time, all four are loaded at once, together with a regular request and duplicate requests.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   typedef enum logic [2:0] {
      DM_FIXED  = 3'd0,
      DM_LOWEST = 3'd1,
      DM_SMM    = 3'd2,
      DM_RSV_A  = 3'd3,
      DM_NMI    = 3'd4,
      DM_INIT   = 3'd5,
      DM_RSV_B  = 3'd6,
      DM_EXT    = 3'd7
   } dmode_e;

   typedef enum logic [2:0] {
      K_NONE = 3'd0,
      K_SMM  = 3'd1,
      K_NMI  = 3'd2,
      K_INIT = 3'd3,
      K_EXT  = 3'd4,
      K_REG  = 3'd5
   } kind_e;

   // special lane slot indices, in precedence order
   localparam int SL_SMM  = 0;
   localparam int SL_NMI  = 1;
   localparam int SL_INIT = 2;
   localparam int SL_EXT  = 3;
   localparam int NUM_SL  = 4;

endpackage

// File: rtl/irq_prio_enc.sv
// Highest-set-bit finder; flat scan or two-level grouped scan.
module irq_prio_enc #(
   parameter int N       = 256,
   parameter int IW      = 8,
   parameter int GROUP_W = 16,
   parameter bit FLAT    = 1'b0
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   localparam int NG  = N / GROUP_W;
   localparam int GIW = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;

   generate
      if ((1 << IW) != N) begin : g_bad_width
         $error("irq_prio_enc: N must equal 2**IW");
      end
      if (!FLAT && ((N % GROUP_W) != 0 || GROUP_W < 2 || NG < 2)) begin : g_bad_group
         $error("irq_prio_enc: GROUP_W must divide N into at least two groups");
      end

      if (FLAT) begin : g_flat
         always_comb begin
            any = 1'b0;
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (vec[i]) begin
                  any = 1'b1;
                  idx = IW'(i);
               end
            end
         end
      end else begin : g_grouped
         logic [NG-1:0]  grp_any;
         logic [GIW-1:0] grp_idx [NG];

         for (genvar g = 0; g < NG; g++) begin : g_grp
            always_comb begin
               grp_any[g] = 1'b0;
               grp_idx[g] = '0;
               for (int b = 0; b < GROUP_W; b++) begin
                  if (vec[g*GROUP_W + b]) begin
                     grp_any[g] = 1'b1;
                     grp_idx[g] = GIW'(b);
                  end
               end
            end
         end

         always_comb begin
            any = 1'b0;
            idx = '0;
            for (int g = 0; g < NG; g++) begin
               if (grp_any[g]) begin
                  any = 1'b1;
                  idx = IW'(g * GROUP_W) + IW'(grp_idx[g]);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_vec_bank.sv
// Request, in-service and trigger arrays with their highest-vector finders.
module irq_vec_bank #(
   parameter int VW      = 8,
   parameter int GROUP_W = 16,
   parameter bit FLAT    = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [VW-1:0] set_idx,
   input  logic          set_level,
   input  logic          ack_reg,
   input  logic          eoi,
   output logic          irr_any,
   output logic [VW-1:0] irr_top,
   output logic          isr_any,
   output logic [VW-1:0] isr_top,
   output logic          top_level
);
   localparam int N = 1 << VW;

   logic [N-1:0] irr_q, isr_q, tmr_q;
   logic [N-1:0] irr_n, isr_n, tmr_n;

   irq_prio_enc #(.N(N), .IW(VW), .GROUP_W(GROUP_W), .FLAT(FLAT)) u_irr_enc (
      .vec(irr_q), .any(irr_any), .idx(irr_top)
   );
   irq_prio_enc #(.N(N), .IW(VW), .GROUP_W(GROUP_W), .FLAT(FLAT)) u_isr_enc (
      .vec(isr_q), .any(isr_any), .idx(isr_top)
   );

   always_comb begin
      irr_n = irr_q;
      isr_n = isr_q;
      tmr_n = tmr_q;
      if (eoi && isr_any) isr_n[isr_top] = 1'b0;
      if (ack_reg) begin
         irr_n[irr_top] = 1'b0;
         isr_n[irr_top] = 1'b1;
      end
      if (set_en) begin
         if (!irr_q[set_idx]) tmr_n[set_idx] = set_level;
         irr_n[set_idx] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
         tmr_q <= '0;
      end else begin
         irr_q <= irr_n;
         isr_q <= isr_n;
         tmr_q <= tmr_n;
      end
   end

   assign top_level = tmr_q[irr_top];

   // R3: a request that hits an already set bit keeps every trigger bit
   p_trig_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && irr_q[set_idx]) |=> $stable(tmr_q));

   // R9: an acknowledged vector moves from request to in-service
   p_ack_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_reg && !eoi && !(set_en && set_idx == irr_top))
      |=> (isr_q[$past(irr_top)] && !irr_q[$past(irr_top)]));

   // R10: end of interrupt retires the highest in-service vector
   p_eoi_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr_any && !(ack_reg && irr_top == isr_top))
      |=> !isr_q[$past(isr_top)]);

endmodule

// File: rtl/irq_special_lane.sv
// One-deep pending slots with latched vectors for the bypass modes.
module irq_special_lane
   import irq_ctrl_pkg::*;
#(
   parameter int VW = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SL-1:0]           hit,
   input  logic [VW-1:0]               req_vector,
   input  logic [NUM_SL-1:0]           clr,
   output logic [NUM_SL-1:0]           pend,
   output logic [NUM_SL-1:0][VW-1:0]   vec
);
   logic [NUM_SL-1:0]         pend_q;
   logic [NUM_SL-1:0][VW-1:0] vec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         vec_q  <= '0;
      end else begin
         for (int s = 0; s < NUM_SL; s++) begin
            if (clr[s]) begin
               pend_q[s] <= 1'b0;
            end else if (hit[s] && !pend_q[s]) begin
               pend_q[s] <= 1'b1;
               vec_q[s]  <= req_vector;
            end
         end
      end
   end

   assign pend = pend_q;
   assign vec  = vec_q;

   generate
      for (genvar s = 0; s < NUM_SL; s++) begin : g_chk
         // R4: a repeat while the slot is full is dropped
         p_drop_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[s] && hit[s] && !clr[s]) |=> (pend_q[s] && $stable(vec_q[s])));
      end
   endgenerate

endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: request decode, offer selection, acknowledge routing and task priority.
module prio_irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int CLASS_W     = 4,
   parameter int TPR_BUS_W   = 32,
   parameter int ENC_GROUP_W = 16,
   parameter bit ENC_FLAT    = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [VEC_W-1:0]     req_vector,
   input  logic [2:0]           req_mode,
   input  logic                 req_level,
   input  logic                 core_ie,
   input  logic                 ack,
   input  logic                 eoi,
   input  logic                 tpr_we,
   input  logic [TPR_BUS_W-1:0] tpr_wdata,
   output logic                 irq_pending,
   output logic [VEC_W-1:0]     irq_vector,
   output logic [2:0]           irq_kind,
   output logic                 irq_level
);
   localparam int CLS_LO = VEC_W - CLASS_W;

   generate
      if (CLASS_W < 1 || CLASS_W > VEC_W) begin : g_bad_class
         $error("prio_irq_ctrl: CLASS_W must lie in 1..VEC_W");
      end
      if (TPR_BUS_W < VEC_W) begin : g_bad_bus
         $error("prio_irq_ctrl: TPR_BUS_W must be at least VEC_W");
      end
   endgenerate

   // request decode
   logic                          arr_set;
   logic [NUM_SL-1:0]             sl_hit, sl_clr, sl_pend;
   logic [NUM_SL-1:0][VEC_W-1:0]  sl_vec;

   always_comb begin
      arr_set         = req_valid && (req_mode == DM_FIXED || req_mode == DM_LOWEST);
      sl_hit          = '0;
      sl_hit[SL_SMM]  = req_valid && (req_mode == DM_SMM);
      sl_hit[SL_NMI]  = req_valid && (req_mode == DM_NMI);
      sl_hit[SL_INIT] = req_valid && (req_mode == DM_INIT);
      sl_hit[SL_EXT]  = req_valid && (req_mode == DM_EXT);
   end

   // task priority
   logic [VEC_W-1:0] tpr_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      tpr_q <= '0;
      else if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
   end

   // arrays
   logic             irr_any, isr_any, top_level, ack_reg;
   logic [VEC_W-1:0] irr_top, isr_top;

   irq_vec_bank #(.VW(VEC_W), .GROUP_W(ENC_GROUP_W), .FLAT(ENC_FLAT)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(arr_set), .set_idx(req_vector), .set_level(req_level),
      .ack_reg(ack_reg), .eoi(eoi),
      .irr_any(irr_any), .irr_top(irr_top),
      .isr_any(isr_any), .isr_top(isr_top),
      .top_level(top_level)
   );

   irq_special_lane #(.VW(VEC_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .hit(sl_hit), .req_vector(req_vector), .clr(sl_clr),
      .pend(sl_pend), .vec(sl_vec)
   );

   // offer selection
   logic  unmask_any, reg_ok;
   kind_e kind_s;

   assign unmask_any = sl_pend[SL_SMM] | sl_pend[SL_NMI] | sl_pend[SL_INIT];
   assign reg_ok = irr_any && (!isr_any || irr_top > isr_top) &&
                   (irr_top[VEC_W-1:CLS_LO] > tpr_q[VEC_W-1:CLS_LO]);

   always_comb begin
      kind_s     = K_NONE;
      irq_vector = '0;
      irq_level  = 1'b0;
      if (sl_pend[SL_SMM]) begin
         kind_s     = K_SMM;
         irq_vector = sl_vec[SL_SMM];
      end else if (sl_pend[SL_NMI]) begin
         kind_s     = K_NMI;
         irq_vector = sl_vec[SL_NMI];
      end else if (sl_pend[SL_INIT]) begin
         kind_s     = K_INIT;
         irq_vector = sl_vec[SL_INIT];
      end else if (core_ie && sl_pend[SL_EXT]) begin
         kind_s     = K_EXT;
         irq_vector = sl_vec[SL_EXT];
      end else if (core_ie && reg_ok) begin
         kind_s     = K_REG;
         irq_vector = irr_top;
         irq_level  = top_level;
      end
   end

   assign irq_kind    = kind_s;
   assign irq_pending = (kind_s != K_NONE);

   // acknowledge routing: only the offered source is retired
   always_comb begin
      sl_clr          = '0;
      sl_clr[SL_SMM]  = ack && (kind_s == K_SMM);
      sl_clr[SL_NMI]  = ack && (kind_s == K_NMI);
      sl_clr[SL_INIT] = ack && (kind_s == K_INIT);
      sl_clr[SL_EXT]  = ack && (kind_s == K_EXT);
      ack_reg         = ack && (kind_s == K_REG);
   end

   // R6: unmaskable slots reach the core with interrupts off
   p_unmask_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sl_pend[SL_SMM] && !core_ie) |-> (irq_kind == K_SMM));

   // R5: with interrupts off and no unmaskable slot, nothing is offered
   p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_ie && !unmask_any) |-> !irq_pending);

   // R7: an offered regular vector is above the task priority class
   p_tpr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_kind == K_REG) |-> (irq_vector[VEC_W-1:CLS_LO] > tpr_q[VEC_W-1:CLS_LO]));

   // R8: at most one source is retired per acknowledge
   p_one_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sl_clr, ack_reg}));

   // R12: reserved mode codes leave all pending state alone
   p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_mode == DM_RSV_A || req_mode == DM_RSV_B) && !ack && !eoi)
      |=> ($stable(sl_pend) && $stable(irr_any) && $stable(irr_top)));

   // R13: quiet outputs when nothing is offered
   p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_pending |-> (irq_vector == '0 && irq_level == 1'b0));

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

   localparam logic [2:0] KN = 3'd0, KS = 3'd1, KM = 3'd2, KI = 3'd3, KE = 3'd4, KR = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vector = '0;
   logic [2:0]  req_mode = '0;
   logic        req_level = 1'b0;
   logic        core_ie = 1'b0;
   logic        ack = 1'b0;
   logic        eoi = 1'b0;
   logic        tpr_we = 1'b0;
   logic [31:0] tpr_wdata = '0;
   logic        irq_pending;
   logic [7:0]  irq_vector;
   logic [2:0]  irq_kind;
   logic        irq_level;

   int n_checks = 0;
   int n_err    = 0;

   always #5 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vector(req_vector), .req_mode(req_mode),
      .req_level(req_level), .core_ie(core_ie), .ack(ack), .eoi(eoi),
      .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
      .irq_pending(irq_pending), .irq_vector(irq_vector),
      .irq_kind(irq_kind), .irq_level(irq_level)
   );

   task automatic check(input string rq, input logic ep, input logic [2:0] ek,
                        input logic [7:0] ev, input logic el);
      n_checks++;
      if (irq_pending !== ep || irq_kind !== ek || irq_vector !== ev || irq_level !== el) begin
         n_err++;
         $display("FAIL %s: got p=%0b k=%0d v=%02h l=%0b expected p=%0b k=%0d v=%02h l=%0b",
                  rq, irq_pending, irq_kind, irq_vector, irq_level, ep, ek, ev, el);
      end
   endtask

   task automatic chk_none(input string rq);
      check(rq, 1'b0, KN, 8'h00, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic send(input logic [2:0] m, input logic [7:0] v, input logic lv);
      req_valid = 1'b1; req_mode = m; req_vector = v; req_level = lv;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      #1;
   endtask

   task automatic pulse_eoi();
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
      #1;
   endtask

   task automatic write_tpr(input logic [31:0] d);
      tpr_we = 1'b1; tpr_wdata = d;
      @(negedge clk);
      tpr_we = 1'b0;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      do_reset();
      chk_none("R13 reset state");

      // R1 / R2: sweep all vectors through request, ack, eoi
      core_ie = 1'b1;
      #1;
      for (int v = 0; v < 256; v++) begin
         logic [7:0] vb;
         logic       lv;
         vb = 8'(v);
         lv = vb[1] ^ vb[4];
         send(vb[2] ? 3'd1 : 3'd0, vb, lv);
         if (vb[7:4] != 4'h0) begin
            check("R1 R2 sweep request", 1'b1, KR, vb, lv);
            pulse_ack();
            chk_none("R9 sweep after ack");
            pulse_eoi();
            chk_none("R10 sweep after eoi");
         end else begin
            chk_none("R7 class zero never offered");
         end
      end

      // R7 / R11: every vector class against every task priority class
      for (int t = 0; t < 16; t++) begin
         for (int c = 1; c < 16; c++) begin
            logic [7:0] vb;
            do_reset();
            core_ie = 1'b1;
            write_tpr(32'hA5C3_0000 | 32'(t << 4) | 32'h0000_0B00 | 32'(c & 7));
            vb = 8'((c << 4) | 5);
            send(3'd0, vb, 1'b0);
            if (c > t) check("R7 R11 tpr gate open", 1'b1, KR, vb, 1'b0);
            else       chk_none("R7 R11 tpr gate shut");
         end
      end

      // R7 / R9 / R10: in-service comparison
      do_reset();
      core_ie = 1'b1;
      send(3'd0, 8'h50, 1'b0);
      pulse_ack();
      chk_none("R9 after ack of 50");
      send(3'd0, 8'h40, 1'b0);
      chk_none("R7 lower than in-service");
      send(3'd1, 8'h50, 1'b0);
      chk_none("R7 equal to in-service");
      pulse_eoi();
      check("R10 eoi releases 50", 1'b1, KR, 8'h50, 1'b0);
      pulse_ack();
      chk_none("R9 40 blocked by 50");
      pulse_eoi();
      check("R10 eoi releases 40", 1'b1, KR, 8'h40, 1'b0);

      // R10: nested in-service
      do_reset();
      core_ie = 1'b1;
      send(3'd0, 8'h30, 1'b0);
      pulse_ack();
      send(3'd0, 8'h70, 1'b1);
      check("R7 nested higher offered", 1'b1, KR, 8'h70, 1'b1);
      pulse_ack();
      send(3'd0, 8'h20, 1'b0);
      chk_none("R7 20 blocked by 70 and 30");
      pulse_eoi();
      chk_none("R10 first eoi retires only 70");
      pulse_eoi();
      check("R10 second eoi releases 20", 1'b1, KR, 8'h20, 1'b0);

      // R3: repeated request keeps trigger bit
      do_reset();
      core_ie = 1'b1;
      send(3'd0, 8'h44, 1'b1);
      send(3'd1, 8'h44, 1'b0);
      check("R3 level kept on repeat", 1'b1, KR, 8'h44, 1'b1);
      pulse_ack();
      pulse_eoi();
      send(3'd0, 8'h45, 1'b0);
      send(3'd0, 8'h45, 1'b1);
      check("R3 edge kept on repeat", 1'b1, KR, 8'h45, 1'b0);

      // R12: reserved codes ignored
      do_reset();
      core_ie = 1'b1;
      send(3'd3, 8'hE0, 1'b1);
      chk_none("R12 code 3 ignored");
      send(3'd6, 8'hE1, 1'b0);
      chk_none("R12 code 6 ignored");

      // R13: ack with nothing offered changes nothing
      pulse_ack();
      chk_none("R13 idle ack");
      send(3'd0, 8'h80, 1'b0);
      check("R13 state intact after idle ack", 1'b1, KR, 8'h80, 1'b0);

      // R4 / R5 / R6 / R8: precedence with interrupts off then on
      do_reset();
      core_ie = 1'b0;
      #1;
      send(3'd4, 8'h22, 1'b0);
      send(3'd4, 8'h66, 1'b0);
      check("R4 R6 nmi repeat dropped", 1'b1, KM, 8'h22, 1'b0);
      send(3'd5, 8'h11, 1'b0);
      send(3'd7, 8'h44, 1'b0);
      send(3'd0, 8'h90, 1'b1);
      send(3'd2, 8'h33, 1'b0);
      send(3'd2, 8'h99, 1'b0);
      check("R8 R6 smm first, repeat dropped", 1'b1, KS, 8'h33, 1'b0);
      pulse_ack();
      check("R8 nmi after smm", 1'b1, KM, 8'h22, 1'b0);
      pulse_ack();
      check("R8 init after nmi", 1'b1, KI, 8'h11, 1'b0);
      send(3'd4, 8'h66, 1'b0);
      check("R4 R8 new nmi over init", 1'b1, KM, 8'h66, 1'b0);
      pulse_ack();
      check("R8 init still held", 1'b1, KI, 8'h11, 1'b0);
      pulse_ack();
      chk_none("R5 external masked");
      core_ie = 1'b1;
      #1;
      check("R5 R8 external when enabled", 1'b1, KE, 8'h44, 1'b0);
      pulse_ack();
      check("R8 regular last", 1'b1, KR, 8'h90, 1'b1);
      pulse_ack();
      chk_none("R8 all retired");

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule